// File: doc/BRIEF.md
# Error Control Register and Trap Arbiter

This block holds a processor's error-control state in two writable bits: a weak-detection bit, which lets execution carry on past some errors, and a handler-active bit, which records that the operating system's error handler is running. Each cycle the block looks at the error events reported by the pipeline and makes one decision. It raises a normal error trap, raises an asynchronous data-error trap, escalates to a multiple-error trap, or suppresses the error. When it suppresses an error it flags the instruction's destination register or store target as unpredictable.

The control bits also change on their own. When an asynchronous data-error trap is taken, the handler-active bit is set. When a RETRY or DONE instruction completes, the bit is cleared. An instruction-side or data-side error that arrives while the handler is active means the handler itself has failed. The block then escalates to a multiple-error trap, and hardware forces weak detection on. Software reads and writes both bits through a plain register port, and every other bit of that register reads back as zero.

The handler-active bit is kept as a two-state machine. `HS_NORMAL` means no handler is running and `HS_HANDLER` means one is. There are four named transitions. `ENTER` fires on a taken asynchronous data-error trap. `EXIT` fires on RETRY/DONE completion. `SW_SET` and `SW_CLR` fire on software writes of bit 0. Hardware transitions win over software ones. `ENTER` wins over `EXIT`.

Top module: `err_ctl_arbiter`

## Requirements
- R1: After reset the register reads 0: weak detection is off and the state is `HS_NORMAL`. All trap outputs and `result_unpredictable` are 0 while no error strobe is high.
- R2: A register write stores data bit 1 as weak detection and data bit 0 as handler-active. A read returns them in those same bit positions, and every other read bit is 0.
- R3: With both control bits 0, an instruction-urgent or data-access error raises `trap_sync` whatever `can_continue` is. An instruction-access error with the handler bit 0 always raises `trap_sync`.
- R4: With weak detection 1, handler-active 0 and `can_continue` 1, an instruction-urgent or data-access error raises no trap, and `result_unpredictable` is 1 in that cycle.
- R5: With weak detection 1 and `can_continue` 0, an instruction-urgent or data-access error still raises `trap_sync`, and `result_unpredictable` stays 0.
- R6: An autonomous urgent error or a restrainable error raises `trap_async` only when both control bits are 0. If either bit is 1, the error raises no trap.
- R7: While handler-active is 1, an instruction-urgent, instruction-access or data-access error raises `trap_multi` and not `trap_sync`.
- R8: In the cycle after `trap_multi`, weak detection reads 1, even if software wrote 0 to it in the same cycle.
- R9: A pulse on `adet_taken` makes handler-active read 1 in the next cycle (`ENTER`). This beats a software write of 0 and a simultaneous `retry_done`.
- R10: A pulse on `retry_done` without `adet_taken` makes handler-active read 0 in the next cycle (`EXIT`). This beats a software write of 1.
- R11: At most one of `trap_multi`, `trap_async` and `trap_sync` is high in any cycle. `trap_multi` outranks `trap_async`, and `trap_async` outranks `trap_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Software write strobe for the control register |
| reg_wr_data | input | DATA_W | Write data; bit 1 is weak detection, bit 0 is handler-active |
| reg_rd_data | output | DATA_W | Read value; bits above 1 are zero |
| err_iuge | input | 1 | Instruction-side urgent error detected |
| err_iae | input | 1 | Instruction access error detected |
| err_dae | input | 1 | Data access error detected |
| err_auge | input | 1 | Autonomous urgent error detected |
| err_rest | input | 1 | Restrainable error detected |
| can_continue | input | 1 | Execution can proceed past the current error |
| adet_taken | input | 1 | An asynchronous data-error trap was taken |
| retry_done | input | 1 | A RETRY or DONE instruction completed |
| trap_sync | output | 1 | Normal error trap request |
| trap_async | output | 1 | Asynchronous data-error trap request |
| trap_multi | output | 1 | Multiple-error trap request |
| result_unpredictable | output | 1 | Error suppressed; destination or store target is unpredictable |

## Verification
The hardest situation to reach from the ports is a software write that lands in the same cycle as a hardware update of the same bit. Examples are a multiple-error trap together with a write that clears weak detection, or a taken trap together with a RETRY/DONE completion and a clearing write. The bench holds the error strobe, the write and the completion strobes together across one rising edge to create these collisions. It then reads the register back to see which source won. Escalation also needs the handler bit set before the error arrives, so the bench first writes it through the register port and then presents the error.

// File: rtl/err_ctl_pkg.sv
package err_ctl_pkg;
    typedef enum logic [1:0] {
        TRAP_NONE  = 2'd0,
        TRAP_SYNC  = 2'd1,
        TRAP_ASYNC = 2'd2,
        TRAP_MULTI = 2'd3
    } trap_kind_t;

    typedef enum logic {
        HS_NORMAL  = 1'b0,
        HS_HANDLER = 1'b1
    } hdl_state_t;

    localparam int unsigned WEAK_BIT = 1;
    localparam int unsigned HDL_BIT  = 0;
endpackage

// File: rtl/err_trap_arb.sv
module err_trap_arb
    import err_ctl_pkg::*;
(
    input  logic       weak_on,
    input  logic       hdl_on,
    input  logic       iuge,
    input  logic       iae,
    input  logic       dae,
    input  logic       auge,
    input  logic       rest,
    input  logic       cont_ok,
    output trap_kind_t kind,
    output logic       unpredictable
);
    logic sync_any;
    logic multi_hit;
    logic async_hit;
    logic sync_hit;
    logic suppress;

    always_comb begin
        sync_any  = iuge | iae | dae;
        multi_hit = hdl_on & sync_any;
        async_hit = ~weak_on & ~hdl_on & (auge | rest);
        suppress  = ~hdl_on & weak_on & cont_ok & (iuge | dae);
        sync_hit  = ~hdl_on & (iae | ((iuge | dae) & ~(weak_on & cont_ok)));
        unpredictable = suppress;
        if (multi_hit)      kind = TRAP_MULTI;
        else if (async_hit) kind = TRAP_ASYNC;
        else if (sync_hit)  kind = TRAP_SYNC;
        else                kind = TRAP_NONE;
    end
endmodule

// File: rtl/err_ctl_regs.sv
module err_ctl_regs
    import err_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_weak,
    input  logic wr_hdl,
    input  logic multi_evt,
    input  logic adet_taken,
    input  logic retry_done,
    output logic weak_q,
    output logic hdl_q
);
    hdl_state_t state_q;
    hdl_state_t state_d;

    // handler-active state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_NORMAL;
        else        state_q <= state_d;
    end

    // transitions: ENTER, EXIT, SW_SET, SW_CLR (hardware first)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_NORMAL: begin
                if (adet_taken)                       state_d = HS_HANDLER; // ENTER
                else if (!retry_done && wr_en && wr_hdl) state_d = HS_HANDLER; // SW_SET
            end
            HS_HANDLER: begin
                if (adet_taken)                       state_d = HS_HANDLER;
                else if (retry_done)                  state_d = HS_NORMAL;  // EXIT
                else if (wr_en && !wr_hdl)            state_d = HS_NORMAL;  // SW_CLR
            end
            default: state_d = HS_NORMAL;
        endcase
    end

    // weak-detection bit: forced on by a multiple-error trap
    always_ff @(posedge clk) begin
        if (!rst_n)         weak_q <= 1'b0;
        else if (multi_evt) weak_q <= 1'b1;
        else if (wr_en)     weak_q <= wr_weak;
    end

    assign hdl_q = (state_q == HS_HANDLER);

    assert_multi_sets_weak_R8: assert property (@(posedge clk) disable iff (!rst_n)
        multi_evt |=> weak_q);
    assert_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adet_taken |=> hdl_q);
    assert_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_done && !adet_taken) |=> !hdl_q);
endmodule

// File: rtl/err_ctl_arbiter.sv
module err_ctl_arbiter
    import err_ctl_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              err_iuge,
    input  logic              err_iae,
    input  logic              err_dae,
    input  logic              err_auge,
    input  logic              err_rest,
    input  logic              can_continue,
    input  logic              adet_taken,
    input  logic              retry_done,
    output logic              trap_sync,
    output logic              trap_async,
    output logic              trap_multi,
    output logic              result_unpredictable
);
    localparam int unsigned CTL_W = 2;
    localparam int unsigned PAD_W = DATA_W - CTL_W;

    logic       weak_q;
    logic       hdl_q;
    trap_kind_t kind;
    logic       unused_wr_hi;

    assign unused_wr_hi = ^reg_wr_data[DATA_W-1:CTL_W];

    err_trap_arb u_arb (
        .weak_on       (weak_q),
        .hdl_on        (hdl_q),
        .iuge          (err_iuge),
        .iae           (err_iae),
        .dae           (err_dae),
        .auge          (err_auge),
        .rest          (err_rest),
        .cont_ok       (can_continue),
        .kind          (kind),
        .unpredictable (result_unpredictable)
    );

    err_ctl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_weak    (reg_wr_data[WEAK_BIT]),
        .wr_hdl     (reg_wr_data[HDL_BIT]),
        .multi_evt  (trap_multi),
        .adet_taken (adet_taken),
        .retry_done (retry_done),
        .weak_q     (weak_q),
        .hdl_q      (hdl_q)
    );

    always_comb begin
        trap_sync  = (kind == TRAP_SYNC);
        trap_async = (kind == TRAP_ASYNC);
        trap_multi = (kind == TRAP_MULTI);
    end

    assign reg_rd_data = {{PAD_W{1'b0}}, weak_q, hdl_q};

    assert_one_trap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_sync, trap_async, trap_multi}));
    assert_strict_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[1:0] == 2'b00 && (err_iuge || err_dae)) |-> (trap_sync || trap_async));
    assert_suppress_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        result_unpredictable |-> (!trap_sync && !trap_multi));
    assert_escalate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[0] && (err_iuge || err_iae || err_dae)) |-> (trap_multi && !trap_sync));
    assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[1:0] != 2'b00) |-> !trap_async);
endmodule

// File: tb/err_ctl_arbiter_bench.sv
module err_ctl_arbiter_bench;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_wr_en;
    logic [DATA_W-1:0] reg_wr_data;
    logic [DATA_W-1:0] reg_rd_data;
    logic err_iuge, err_iae, err_dae, err_auge, err_rest, can_continue;
    logic adet_taken, retry_done;
    logic trap_sync, trap_async, trap_multi, result_unpredictable;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    err_ctl_arbiter #(.DATA_W(DATA_W)) u_err_ctl_arbiter (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .err_iuge(err_iuge), .err_iae(err_iae),
        .err_dae(err_dae), .err_auge(err_auge), .err_rest(err_rest),
        .can_continue(can_continue), .adet_taken(adet_taken), .retry_done(retry_done),
        .trap_sync(trap_sync), .trap_async(trap_async), .trap_multi(trap_multi),
        .result_unpredictable(result_unpredictable)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr_en = 0; reg_wr_data = '0;
        err_iuge = 0; err_iae = 0; err_dae = 0; err_auge = 0; err_rest = 0;
        can_continue = 0; adet_taken = 0; retry_done = 0;
    endtask

    // outputs packed as {multi, async, sync, unpredictable}
    function automatic logic [3:0] outs();
        return {trap_multi, trap_async, trap_sync, result_unpredictable};
    endfunction

    // drive errors at a falling edge, sample, release before the rising edge
    task automatic probe(input logic [4:0] e, input logic cc, output logic [3:0] o);
        @(negedge clk);
        {err_iuge, err_iae, err_dae, err_auge, err_rest} = e;
        can_continue = cc;
        #1 o = outs();
        #1 idle();
    endtask

    // hold strobes across one rising edge
    task automatic cycle(input logic wr, input logic [1:0] wd, input logic tk,
                         input logic rd, input logic [4:0] e);
        @(negedge clk);
        reg_wr_en = wr; reg_wr_data = {62'd0, wd};
        adet_taken = tk; retry_done = rd;
        {err_iuge, err_iae, err_dae, err_auge, err_rest} = e;
        @(negedge clk);
        idle();
    endtask

    task automatic wr_reg(input logic [1:0] v);
        cycle(1'b1, v, 1'b0, 1'b0, 5'b0);
    endtask

    task automatic t_reset();
        #1 check("R1 read", reg_rd_data, 64'd0);
        check("R1 outs", outs(), 4'b0);
    endtask

    task automatic t_swrw();
        @(negedge clk);
        reg_wr_en = 1; reg_wr_data = '1;
        @(negedge clk); idle();
        check("R2 all ones", reg_rd_data, 64'd3);
        wr_reg(2'b10); check("R2 weak only", reg_rd_data, 64'd2);
        wr_reg(2'b01); check("R2 hdl only", reg_rd_data, 64'd1);
        wr_reg(2'b00); check("R2 clear", reg_rd_data, 64'd0);
    endtask

    task automatic t_strict();
        logic [3:0] o;
        wr_reg(2'b00);
        probe(5'b10000, 1'b1, o); check("R3 iuge cc", o, 4'b0010);
        probe(5'b00100, 1'b1, o); check("R3 dae cc", o, 4'b0010);
        probe(5'b00100, 1'b0, o); check("R3 dae nocc", o, 4'b0010);
        probe(5'b01000, 1'b1, o); check("R3 iae", o, 4'b0010);
    endtask

    task automatic t_weak();
        logic [3:0] o;
        wr_reg(2'b10);
        probe(5'b10000, 1'b1, o); check("R4 iuge suppressed", o, 4'b0001);
        probe(5'b00100, 1'b1, o); check("R4 dae suppressed", o, 4'b0001);
        probe(5'b00100, 1'b0, o); check("R5 dae nocc", o, 4'b0010);
        probe(5'b10000, 1'b0, o); check("R5 iuge nocc", o, 4'b0010);
        probe(5'b01000, 1'b1, o); check("R3 iae under weak", o, 4'b0010);
        wr_reg(2'b00);
    endtask

    task automatic t_async();
        logic [3:0] o;
        probe(5'b00010, 1'b0, o); check("R6 auge open", o, 4'b0100);
        probe(5'b00001, 1'b0, o); check("R6 rest open", o, 4'b0100);
        wr_reg(2'b10);
        probe(5'b00001, 1'b0, o); check("R6 rest masked weak", o, 4'b0000);
        wr_reg(2'b01);
        probe(5'b00010, 1'b0, o); check("R6 auge masked hdl", o, 4'b0000);
        wr_reg(2'b00);
    endtask

    task automatic t_priority();
        logic [3:0] o;
        probe(5'b10010, 1'b0, o); check("R11 async over sync", o, 4'b0100);
        wr_reg(2'b01);
        probe(5'b00111, 1'b0, o); check("R11 multi over async", o, 4'b1000);
        wr_reg(2'b00);
    endtask

    task automatic t_multi();
        logic [3:0] o;
        wr_reg(2'b01);
        probe(5'b01000, 1'b1, o); check("R7 iae escalates", o, 4'b1000);
        probe(5'b10000, 1'b1, o); check("R7 iuge escalates", o, 4'b1000);
        check("R8 no edge no set", reg_rd_data, 64'd1);
        cycle(1'b1, 2'b01, 1'b0, 1'b0, 5'b00100);
        check("R8 weak forced over write", reg_rd_data, 64'd3);
        wr_reg(2'b00);
    endtask

    task automatic t_handler();
        cycle(1'b0, 2'b00, 1'b1, 1'b0, 5'b0);
        check("R9 enter", reg_rd_data, 64'd1);
        cycle(1'b0, 2'b00, 1'b0, 1'b1, 5'b0);
        check("R10 exit", reg_rd_data, 64'd0);
        cycle(1'b1, 2'b00, 1'b1, 1'b0, 5'b0);
        check("R9 enter over write", reg_rd_data, 64'd1);
        cycle(1'b1, 2'b01, 1'b0, 1'b1, 5'b0);
        check("R10 exit over write", reg_rd_data, 64'd0);
        cycle(1'b1, 2'b00, 1'b1, 1'b1, 5'b0);
        check("R9 enter over exit", reg_rd_data, 64'd1);
        wr_reg(2'b00);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset();
        t_swrw();
        t_strict();
        t_weak();
        t_async();
        t_priority();
        t_multi();
        t_handler();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule